// File: doc/BRIEF.md
# Free-Queue Descriptor Prefetch FIFO

A host posts receive buffer descriptors into a circular free queue in memory. This block keeps a small local cache of those descriptors, so a receive DMA engine can take one in the same cycle it asks, instead of paying a memory round trip for every packet. The block compares the host's write offset with its own read offset to see how many descriptors have been posted. When the local occupancy of a queue falls to a low watermark, it issues one burst read for as many descriptors as are posted, will fit locally, and lie before the ring's end.

The ring can be one shared queue or two queues, one for large buffers and one for small buffers. The choice comes from the configuration. When the small-queue start address equals the ring end address, the block runs one queue over the whole local store. Otherwise the store is split evenly between the two queues. Any prefetching is gated by an enable bit. With the bit clear, the block fetches a single descriptor only when a queue's cache is empty. The configuration is expected to stay static between resets. Four sticky status bits report completed fetches and starved queues, and each of them can drive the interrupt output.

Top module: `fq_prefetch`

## Requirements
- R1: The block is in single mode when `cfg_sm_start == cfg_q_end`, and then holds up to DEPTH (16) descriptors in one queue spanning `cfg_q_start` to `cfg_q_end`-1. In this mode pops are served from that queue whatever `pop_sel` says. Otherwise the large queue spans `cfg_q_start` to `cfg_sm_start`-1 and the small queue spans `cfg_sm_start` to `cfg_q_end`-1, each holding up to DEPTH/2 (8) descriptors.
- R2: When enabled and idle, a queue requests a refill exactly when it has posted descriptors and its occupancy is at or below the watermark. The watermark is 4 in single mode and 2 per queue in dual mode. No request is issued otherwise.
- R3: `req_len` equals min(available, capacity − occupancy, queue length − read offset). Available is (host write offset − read offset) modulo the queue length, so no read ever passes the posted descriptors or the ring end.
- R4: When a queue needs a refill but has nothing posted, its starve status bit is set, no request is issued, and its read offset is unchanged. Bit 2 is for the large or single queue and bit 3 for the small queue.
- R5: `req_addr` is the queue start plus the read offset, in descriptor units. After the last response beat, the read offset advances by `req_len` and wraps to 0 at the queue length. The fetch-done status bit for that queue is then set: bit 0 for the large or single queue, bit 1 for the small queue.
- R6: Only one burst is outstanding. `req_valid` with `req_addr`, `req_len` and `req_sel` holds steady until `req_ready`. `req_sel` is 0 for the large or single queue and 1 for the small queue.
- R7: With `cfg_fifo_en` clear, a queue requests exactly one descriptor, and only when its cache is empty.
- R8: `pop_valid` rises in the same cycle as `pop_req` when the selected queue is non-empty, and `pop_desc` then returns that queue's descriptors in ring order. When the selected queue is empty, `pop_valid` is 0 and nothing changes.
- R9: Status bits reset to 0, stay set until a 1 is written to the same bit of `stat_clr`, and a new set event in the same cycle wins over the clear.
- R10: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.
- R11: When both queues are due for a refill, the large queue is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | Prefetch enable; when clear, single on-demand fetches |
| cfg_q_start | input | AW | Ring start (large or single queue base) |
| cfg_sm_start | input | AW | Small queue base; equal to end selects single mode |
| cfg_q_end | input | AW | Ring end, exclusive |
| host_wp_lg | input | AW | Host write offset of large or single queue |
| host_wp_sm | input | AW | Host write offset of small queue |
| req_valid | output | 1 | Burst read request |
| req_ready | input | 1 | Request accepted |
| req_addr | output | AW | First descriptor address |
| req_len | output | IW+1 | Descriptor count |
| req_sel | output | 1 | Target queue, 0 large or single, 1 small |
| rsp_valid | input | 1 | One descriptor returned |
| rsp_desc | input | 2*DW | Returned descriptor |
| pop_req | input | 1 | DMA takes a descriptor |
| pop_sel | input | 1 | Queue to take from |
| pop_valid | output | 1 | Descriptor present this cycle |
| pop_desc | output | 2*DW | Descriptor at head of queue |
| stat | output | 4 | Sticky status bits |
| stat_clr | input | 4 | Write-one-to-clear for status |
| irq_en | input | 4 | Per-bit interrupt enable |
| irq | output | 1 | Interrupt |

## Verification
The bench runs four modes: single and split queues, each with prefetch on and off. In every mode it posts descriptors in varied increments that wrap the ring. It pops in runs of zero to five, which sometimes go past the cache contents. Small posts against an empty cache check that burst length is cut to the posted count. Posts that reach the ring end check the clip at the wrap. Popping a full cache down to the watermark checks the trigger point and the cut to free room. After each quiet phase the status bits are cleared, to see which starve bits come back. This separates a correct watermark and error path from one that reads too early or moves the pointer on a failed refill.

// File: rtl/fq_prefetch.sv
module fq_prefetch #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_fifo_en,
  input  logic [AW-1:0]   cfg_q_start,
  input  logic [AW-1:0]   cfg_sm_start,
  input  logic [AW-1:0]   cfg_q_end,
  input  logic [AW-1:0]   host_wp_lg,
  input  logic [AW-1:0]   host_wp_sm,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [CW-1:0]   req_len,
  output logic            req_sel,
  input  logic            rsp_valid,
  input  logic [2*DW-1:0] rsp_desc,
  input  logic            pop_req,
  input  logic            pop_sel,
  output logic            pop_valid,
  output logic [2*DW-1:0] pop_desc,
  output logic [3:0]      stat,
  input  logic [3:0]      stat_clr,
  input  logic [3:0]      irq_en,
  output logic            irq
);
  localparam int HALF = DEPTH / 2;

  typedef enum logic [1:0] {IDLE, REQ, WAIT} state_t;
  state_t state;

  logic          single;
  logic [CW-1:0] cap, wm;
  logic [IW-1:0] rmask;
  assign single = cfg_sm_start == cfg_q_end;
  assign cap    = !cfg_fifo_en ? CW'(1) : single ? CW'(DEPTH) : CW'(HALF);
  assign wm     = !cfg_fifo_en ? '0 : single ? CW'(DEPTH/4) : CW'(DEPTH/8);
  assign rmask  = single ? IW'(DEPTH-1) : IW'(HALF-1);

  logic [AW-1:0] qbase [2], qlen [2], wp [2], rp [2], avail [2], room [2], nb [2];
  logic [CW-1:0] cnt [2];
  logic [IW-1:0] head [2];
  logic          need [2], go [2], starve [2], wr [2], pp [2];
  logic [2*DW-1:0] mem [DEPTH];

  assign qbase[0] = cfg_q_start;
  assign qbase[1] = cfg_sm_start;
  assign qlen[0]  = single ? cfg_q_end - cfg_q_start : cfg_sm_start - cfg_q_start;
  assign qlen[1]  = cfg_q_end - cfg_sm_start;
  assign wp[0]    = host_wp_lg;
  assign wp[1]    = host_wp_sm;

  function automatic logic [AW-1:0] min2(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [IW-1:0] slot(input logic q, input logic sgl);
    return (q && !sgl) ? IW'(HALF) : '0;
  endfunction

  logic          sel_q;
  logic [CW-1:0] n_q, beats;
  logic          psel, pick, done;

  assign psel = single ? 1'b0 : pop_sel;
  assign pick = go[0] ? 1'b0 : 1'b1;
  assign done = state == WAIT && rsp_valid && beats == n_q - CW'(1);

  for (genvar q = 0; q < 2; q++) begin : g_q
    assign avail[q]  = (wp[q] >= rp[q]) ? wp[q] - rp[q] : wp[q] + qlen[q] - rp[q];
    assign room[q]   = qlen[q] - rp[q];
    assign nb[q]     = min2(min2(avail[q], AW'(cap - cnt[q])), room[q]);
    assign need[q]   = (q == 0 || !single) && cnt[q] <= wm;
    assign go[q]     = need[q] && avail[q] != '0;
    assign starve[q] = need[q] && avail[q] == '0;
    assign wr[q]     = state == WAIT && rsp_valid && sel_q == 1'(q);
    assign pp[q]     = pop_valid && psel == 1'(q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[q]  <= '0;
        head[q] <= '0;
        rp[q]   <= '0;
      end else begin
        cnt[q]  <= cnt[q] + CW'(wr[q]) - CW'(pp[q]);
        if (pp[q]) head[q] <= (head[q] + IW'(1)) & rmask;
        if (done && sel_q == 1'(q))
          rp[q] <= (rp[q] + AW'(n_q) == qlen[q]) ? '0 : rp[q] + AW'(n_q);
      end
    end
  end

  assign pop_valid = pop_req && cnt[psel] != '0;
  assign pop_desc  = mem[slot(psel, single) + (head[psel] & rmask)];

  always_ff @(posedge clk)
    if (state == WAIT && rsp_valid)
      mem[slot(sel_q, single) + ((head[sel_q] + cnt[sel_q][IW-1:0]) & rmask)] <= rsp_desc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      sel_q    <= 1'b0;
      n_q      <= '0;
      beats    <= '0;
      req_addr <= '0;
    end else begin
      case (state)
        IDLE: if (go[0] || go[1]) begin
          sel_q    <= pick;
          n_q      <= CW'(nb[pick]);
          req_addr <= qbase[pick] + rp[pick];
          state    <= REQ;
        end
        REQ: if (req_ready) begin
          beats <= '0;
          state <= WAIT;
        end
        default: if (rsp_valid) begin
          beats <= beats + CW'(1);
          if (done) state <= IDLE;
        end
      endcase
    end
  end

  assign req_valid = state == REQ;
  assign req_len   = n_q;
  assign req_sel   = sel_q;

  logic [3:0] set_bits;
  assign set_bits = {starve[1] && state == IDLE, starve[0] && state == IDLE,
                     done && sel_q, done && !sel_q};

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~stat_clr) | set_bits;
  end

  assign irq = |(stat & irq_en);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_sel));

  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != '0 && req_len <= cap);

  a_r4_starve_flag: assert property (@(posedge clk) disable iff (!rst_n)
    state == IDLE && starve[0] |=> stat[2]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~stat_clr)) |=> (stat & $past(stat & ~stat_clr)) == $past(stat & ~stat_clr));

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= CW'(DEPTH) && cnt[1] <= CW'(HALF));
endmodule

// File: tb/fq_prefetch_tb.sv
module fq_prefetch_tb;
  localparam int CLK_NS = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fifo_en = 1'b0;
  logic [AW-1:0] cfg_q_start = '0, cfg_sm_start = '0, cfg_q_end = '0;
  logic [AW-1:0] host_wp_lg = '0, host_wp_sm = '0;
  logic req_valid, req_ready = 1'b0, req_sel;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_len;
  logic rsp_valid = 1'b0;
  logic [2*DW-1:0] rsp_desc = '0;
  logic pop_req = 1'b0, pop_sel = 1'b0, pop_valid;
  logic [2*DW-1:0] pop_desc;
  logic [3:0] stat, stat_clr = '0, irq_en = '0;
  logic irq;

  fq_prefetch #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int qb[2], ql[2], rpm[2], wpm[2], occ[2], poff[2];
  bit sgl, en;
  int capv, wmv;
  bit burst_seen[2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int avail_m(input int q);
    if (ql[q] == 0) return 0;
    return (wpm[q] - rpm[q] + ql[q]) % ql[q];
  endfunction

  function automatic bit need_m(input int q);
    return (q == 0 || !sgl) && occ[q] <= wmv;
  endfunction

  function automatic int imin(input int a, input int b);
    return a < b ? a : b;
  endfunction

  task automatic service();
    bit seen, g0, g1;
    int q, n;
    for (int it = 0; it < 64; it++) begin
      seen = 0;
      for (int w = 0; w < 5 && !seen; w++) begin
        @(negedge clk);
        if (req_valid) seen = 1;
      end
      g0 = need_m(0) && avail_m(0) > 0;
      g1 = need_m(1) && avail_m(1) > 0;
      if (!seen) begin
        chk(!(g0 || g1), "R2 refill request missing", 0, 1);
        return;
      end
      chk(g0 || g1, "R2 request without need", 1, 0);
      q = g0 ? 0 : 1;
      n = imin(imin(avail_m(q), capv - occ[q]), ql[q] - rpm[q]);
      chk(req_sel == q[0], "R11 queue choice", int'(req_sel), q);
      chk(req_addr == AW'(qb[q] + rpm[q]), "R5 request address", int'(req_addr), qb[q] + rpm[q]);
      chk(req_len == CW'(n), "R3 burst length", int'(req_len), n);
      if (!en) chk(occ[q] == 0 && n == 1, "R7 on-demand single fetch", int'(req_len), 1);
      if (it % 2 == 1) begin
        @(negedge clk);
        @(negedge clk);
        chk(req_valid && req_addr == AW'(qb[q] + rpm[q]) && req_len == CW'(n),
            "R6 request held", int'(req_valid), 1);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      for (int b = 0; b < int'(req_len); b++) begin
        rsp_valid = 1'b1;
        rsp_desc  = {DW'(q), DW'(qb[q] + (rpm[q] + b) % ql[q])};
        @(negedge clk);
      end
      rsp_valid = 1'b0;
      occ[q] += n;
      rpm[q] = (rpm[q] + n) % ql[q];
      burst_seen[q] = 1;
    end
  endtask

  task automatic status_check();
    bit e0, e1;
    chk(stat[1:0] == {burst_seen[1], burst_seen[0]}, "R5 fetch-done bits",
        int'(stat[1:0]), int'({burst_seen[1], burst_seen[0]}));
    chk(irq == |(stat & irq_en), "R10 interrupt", int'(irq), int'(|(stat & irq_en)));
    stat_clr = 4'hF;
    @(negedge clk);
    stat_clr = 4'h0;
    @(negedge clk);
    e0 = need_m(0) && avail_m(0) == 0;
    e1 = need_m(1) && avail_m(1) == 0;
    chk(stat == {e1, e0, 2'b00}, "R4 starve bits after R9 clear", int'(stat), int'({e1, e0, 2'b00}));
    chk(!req_valid, "R4 no request while starved", int'(req_valid), 0);
    burst_seen[0] = 0;
    burst_seen[1] = 0;
  endtask

  task automatic pop_n(input bit s, input int cnt);
    int eq;
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      pop_req = 1'b1;
      pop_sel = s;
      #1;
      eq = sgl ? 0 : int'(s);
      if (occ[eq] > 0) begin
        chk(pop_valid, "R8 pop valid", int'(pop_valid), 1);
        chk(pop_desc == {DW'(eq), DW'(qb[eq] + poff[eq])},
            sgl ? "R1 single-queue pop data" : "R8 pop data",
            int'(pop_desc[DW-1:0]), qb[eq] + poff[eq]);
        occ[eq]--;
        poff[eq] = (poff[eq] + 1) % ql[eq];
      end else begin
        chk(!pop_valid, "R8 empty pop", int'(pop_valid), 0);
      end
      @(negedge clk);
      pop_req = 1'b0;
      service();
    end
  endtask

  initial begin
    int q, a, spare;
    for (int m = 0; m < 4; m++) begin
      sgl = (m % 2 == 0);
      en  = (m < 2);
      cfg_fifo_en  = en;
      cfg_q_start  = sgl ? AW'(3) : AW'(2);
      cfg_q_end    = sgl ? AW'(23) : AW'(24);
      cfg_sm_start = sgl ? AW'(23) : AW'(14);
      irq_en       = (m % 2 == 0) ? 4'b1111 : 4'b0101;
      qb[0] = int'(cfg_q_start);
      qb[1] = int'(cfg_sm_start);
      ql[0] = sgl ? 20 : 12;
      ql[1] = sgl ? 0 : 10;
      capv  = !en ? 1 : sgl ? 16 : 8;
      wmv   = !en ? 0 : sgl ? 4 : 2;
      for (int i = 0; i < 2; i++) begin
        rpm[i] = 0; wpm[i] = 0; occ[i] = 0; poff[i] = 0; burst_seen[i] = 0;
      end
      host_wp_lg = '0;
      host_wp_sm = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      if (m == 0) begin
        chk(stat == 4'h0, "R9 reset status", int'(stat), 0);
        chk(!req_valid, "R6 reset request", int'(req_valid), 0);
        chk(!irq, "R10 reset interrupt", int'(irq), 0);
      end
      rst_n = 1'b1;
      service();
      status_check();
      for (int step = 0; step < 30; step++) begin
        q = sgl ? 0 : step % 2;
        spare = ql[q] - 1 - avail_m(q);
        a = imin(1 + (step * 5) % 9, spare);
        if (step % 7 == 6) a = 0;
        wpm[q] = (wpm[q] + a) % ql[q];
        @(negedge clk);
        host_wp_lg = AW'(wpm[0]);
        host_wp_sm = AW'(wpm[1]);
        service();
        status_check();
        pop_n(step[0], step % 6);
        status_check();
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule